// File: doc/BRIEF.md
# Radix-4 Time-Shared Add-Compare-Select Array

This block is the path metric update of a state-parallel Viterbi detector whose trellis has 128 states, with four branches arriving at every state. On each accepted symbol it folds a full set of branch metrics into the stored state metrics. It then presents all 128 new metrics together, along with a 2-bit survivor decision per state that names the winning predecessor. The traceback store that consumes these decisions sits outside the block.

States are wired in groups of four. Every group shares one set of four predecessor states, which keeps metric routing local to the group. Each group holds two add-compare-select units. Each unit owns two neighbouring states and serves them in two consecutive clock slots: the first slot resolves the even state and parks the result, and the second resolves the odd state and commits both. The array therefore needs half as many selectors as there are states, and accepts a new symbol every second clock.

Metrics are unsigned and wrap modulo their width. A candidate wins only if its difference from the current best is positive when read as a signed number, so no renormalisation pass is needed.

Top module: `viterbi_pm_r4`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, every state metric reads 0, every decision reads 0 and `pm_valid_o` reads 0 until the first accepted symbol completes.
- R2: The four predecessors of new state j are the states (j>>2) + k*(N_STATES/4) for k = 0..3. The branch metric for slot k of state j occupies bits [(4j+k)*BMW +: BMW] of `bm_i`.
- R3: The new metric of state j, at bits [j*MW +: MW] of `pm_o`, is the largest of the four sums (predecessor metric + branch metric), taken modulo 2^MW.
- R4: The decision of state j, at bits [2j +: 2] of `dec_o`, is the slot k of the winning sum. When sums are equal, the lowest k wins.
- R5: Selection stays correct after metrics wrap past 2^MW, as long as live metrics lie within 2^(MW-1) of each other.
- R6: A strobe accepted at clock edge E makes all metrics and decisions change together at edge E+1, with `pm_valid_o` high for exactly the cycle that follows E+1.
- R7: A strobe present at the edge right after an accepted strobe is ignored. It causes no second update and no valid pulse.
- R8: Between updates, `pm_o` and `dec_o` hold their values.
- R9: Strobes every second clock are all accepted, and each yields its own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid_i | input | 1 | Symbol strobe; `bm_i` is sampled at the same edge |
| bm_i | input | N_STATES*4*BMW | Branch metrics, one field per state and entry slot |
| pm_o | output | N_STATES*MW | Registered state metrics |
| dec_o | output | N_STATES*2 | Registered survivor decisions |
| pm_valid_o | output | 1 | One-cycle pulse when a new set is presented |

## Verification
A table-driven sequence starts from equal metrics. Zero and constant branch metrics expose tie handling. A ramp rising with the slot index, and another falling with it, show whether the decision follows the slot number and whether slot ordering is wired correctly. Pseudo-random patterns then separate the predecessor mapping and the per-state branch field positions. A long burst at the maximum strobe rate carries the metrics well past wrap-around, which tests the signed-difference comparison and the parking of the even result. A doubled strobe shows that a strobe arriving in the second slot is ignored. A bus that changes after the strobe shows that the odd state uses the branch metrics captured at the strobe edge.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  localparam int RADIX = 4;
  localparam int DEC_W = 2;
  typedef logic [DEC_W-1:0] dec_t;
endpackage

// File: rtl/r4_acs_core.sv
module r4_acs_core
  import vpm_pkg::*;
#(
  parameter int MW  = 12,
  parameter int BMW = 8
) (
  input  logic [RADIX-1:0][MW-1:0]  pm_in,
  input  logic [RADIX-1:0][BMW-1:0] bm_in,
  output logic [MW-1:0]             pm_out,
  output dec_t                      dec_out
);
  // cand beats inc when (cand - inc) is strictly positive as a signed value
  function automatic logic beats(input logic [MW-1:0] cand, input logic [MW-1:0] inc);
    logic [MW-1:0] d;
    d = cand - inc;
    return (d != '0) && !d[MW-1];
  endfunction

  logic [RADIX-1:0][MW-1:0] sum;
  logic [MW-1:0] m01, m23;
  logic w01, w23, wf;

  for (genvar k = 0; k < RADIX; k++) begin : g_add
    assign sum[k] = pm_in[k] + MW'(bm_in[k]);
  end

  always_comb begin
    w01     = beats(sum[1], sum[0]);
    m01     = w01 ? sum[1] : sum[0];
    w23     = beats(sum[3], sum[2]);
    m23     = w23 ? sum[3] : sum[2];
    wf      = beats(m23, m01);
    pm_out  = wf ? m23 : m01;
    dec_out = wf ? {1'b1, w23} : {1'b0, w01};
  end
endmodule

// File: rtl/acs_dual_slot.sv
module acs_dual_slot
  import vpm_pkg::*;
#(
  parameter int MW  = 12,
  parameter int BMW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      accept_i,
  input  logic                      slot1_i,
  input  logic [RADIX-1:0][MW-1:0]  pm_pred_i,
  input  logic [RADIX-1:0][BMW-1:0] bm_even_i,
  input  logic [RADIX-1:0][BMW-1:0] bm_odd_i,
  output logic [MW-1:0]             pm_even_o,
  output logic [MW-1:0]             pm_odd_o,
  output dec_t                      dec_even_o,
  output dec_t                      dec_odd_o
);
  logic [RADIX-1:0][BMW-1:0] bm_sel;
  logic [MW-1:0] core_m, hold_m;
  dec_t          core_d, hold_d;

  assign bm_sel = slot1_i ? bm_odd_i : bm_even_i;

  r4_acs_core #(.MW(MW), .BMW(BMW)) u_core (
    .pm_in  (pm_pred_i),
    .bm_in  (bm_sel),
    .pm_out (core_m),
    .dec_out(core_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_m     <= '0;
      hold_d     <= '0;
      pm_even_o  <= '0;
      pm_odd_o   <= '0;
      dec_even_o <= '0;
      dec_odd_o  <= '0;
    end else begin
      if (accept_i) begin
        hold_m <= core_m;
        hold_d <= core_d;
      end
      if (slot1_i) begin
        pm_even_o  <= hold_m;
        dec_even_o <= hold_d;
        pm_odd_o   <= core_m;
        dec_odd_o  <= core_d;
      end
    end
  end
endmodule

// File: rtl/r4_butterfly.sv
module r4_butterfly
  import vpm_pkg::*;
#(
  parameter int MW  = 12,
  parameter int BMW = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 accept_i,
  input  logic                                 slot1_i,
  input  logic [RADIX-1:0][MW-1:0]             pm_pred_i,
  input  logic [RADIX-1:0][RADIX-1:0][BMW-1:0] bm_now_i,
  input  logic [1:0][RADIX-1:0][BMW-1:0]       bm_odd_i,
  output logic [RADIX-1:0][MW-1:0]             pm_o,
  output logic [RADIX-1:0][DEC_W-1:0]          dec_o
);
  for (genvar u = 0; u < 2; u++) begin : g_unit
    acs_dual_slot #(.MW(MW), .BMW(BMW)) u_acs (
      .clk       (clk),
      .rst       (rst),
      .accept_i  (accept_i),
      .slot1_i   (slot1_i),
      .pm_pred_i (pm_pred_i),
      .bm_even_i (bm_now_i[2*u]),
      .bm_odd_i  (bm_odd_i[u]),
      .pm_even_o (pm_o[2*u]),
      .pm_odd_o  (pm_o[2*u+1]),
      .dec_even_o(dec_o[2*u]),
      .dec_odd_o (dec_o[2*u+1])
    );
  end
endmodule

// File: rtl/viterbi_pm_r4.sv
module viterbi_pm_r4
  import vpm_pkg::*;
#(
  parameter int N_STATES = 128,
  parameter int MW       = 12,
  parameter int BMW      = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sym_valid_i,
  input  logic [N_STATES*RADIX*BMW-1:0]   bm_i,
  output logic [N_STATES*MW-1:0]          pm_o,
  output logic [N_STATES*DEC_W-1:0]       dec_o,
  output logic                            pm_valid_o
);
  localparam int N_GRP  = N_STATES / RADIX;
  localparam int N_PAIR = N_STATES / 2;
  localparam int SLICE  = RADIX * BMW;

  logic slot1_q;
  logic accept;
  logic [N_PAIR-1:0][RADIX-1:0][BMW-1:0] bm_odd_q;

  assign accept = sym_valid_i & ~slot1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot1_q    <= 1'b0;
      pm_valid_o <= 1'b0;
    end else begin
      slot1_q    <= accept;
      pm_valid_o <= slot1_q;
    end
  end

  // only odd states need their branch metrics kept for the second slot
  always_ff @(posedge clk) begin
    if (accept) begin
      for (int p = 0; p < N_PAIR; p++)
        bm_odd_q[p] <= bm_i[(2*p+1)*SLICE +: SLICE];
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [RADIX-1:0][MW-1:0]             pred;
    logic [RADIX-1:0][RADIX-1:0][BMW-1:0] bm_now;
    logic [1:0][RADIX-1:0][BMW-1:0]       bm_odd;
    logic [RADIX-1:0][MW-1:0]             pm_grp;
    logic [RADIX-1:0][DEC_W-1:0]          dec_grp;

    for (genvar k = 0; k < RADIX; k++) begin : g_pred
      assign pred[k] = pm_o[(g + k*N_GRP)*MW +: MW];
    end
    assign bm_now = bm_i[g*RADIX*SLICE +: RADIX*SLICE];
    assign bm_odd = {bm_odd_q[2*g+1], bm_odd_q[2*g]};

    r4_butterfly #(.MW(MW), .BMW(BMW)) u_bfly (
      .clk      (clk),
      .rst      (rst),
      .accept_i (accept),
      .slot1_i  (slot1_q),
      .pm_pred_i(pred),
      .bm_now_i (bm_now),
      .bm_odd_i (bm_odd),
      .pm_o     (pm_grp),
      .dec_o    (dec_grp)
    );

    assign pm_o[g*RADIX*MW +: RADIX*MW]        = pm_grp;
    assign dec_o[g*RADIX*DEC_W +: RADIX*DEC_W] = dec_grp;
  end
endmodule

// File: rtl/viterbi_pm_r4_chk.sv
module viterbi_pm_r4_chk #(
  parameter int N_STATES = 128,
  parameter int MW       = 12,
  parameter int BMW      = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        sym_valid_i,
  input logic [N_STATES*MW-1:0]      pm_o,
  input logic [N_STATES*2-1:0]       dec_o,
  input logic                        pm_valid_o
);
  // R6: a valid pulse traces back to a strobe two edges earlier
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
    pm_valid_o |-> $past(sym_valid_i, 2));

  // R9: one pulse per update, never two in a row
  a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
    pm_valid_o |=> !pm_valid_o);

  // R8: metrics and decisions only move with a valid pulse
  a_r8_pm_hold: assert property (@(posedge clk) disable iff (rst)
    !pm_valid_o |-> $stable(pm_o));

  a_r8_dec_hold: assert property (@(posedge clk) disable iff (rst)
    !pm_valid_o |-> $stable(dec_o));

  // R7: a strobe following a freshly accepted one yields no pulse
  a_r7_second_slot_ignored: assert property (@(posedge clk) disable iff (rst)
    (sym_valid_i && $past(sym_valid_i) && !$past(sym_valid_i, 2)) |-> ##2 !pm_valid_o);
endmodule

bind viterbi_pm_r4 viterbi_pm_r4_chk #(
  .N_STATES(N_STATES), .MW(MW), .BMW(BMW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sym_valid_i(sym_valid_i),
  .pm_o       (pm_o),
  .dec_o      (dec_o),
  .pm_valid_o (pm_valid_o)
);

// File: tb/sim_viterbi_pm_r4.sv
module sim_viterbi_pm_r4;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 128;
  localparam int MW  = 12;
  localparam int BMW = 8;
  localparam int NG  = N / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid_i = 1'b0;
  logic [N*4*BMW-1:0] bm_i = '0;
  logic [N*MW-1:0]    pm_o;
  logic [N*2-1:0]     dec_o;
  logic               pm_valid_o;

  int checks = 0;
  int errors = 0;
  longint ref_pm [N];
  int     ref_dec[N];
  int     bmv    [N][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  viterbi_pm_r4 #(.N_STATES(N), .MW(MW), .BMW(BMW)) u0 (
    .clk(clk), .rst(rst), .sym_valid_i(sym_valid_i), .bm_i(bm_i),
    .pm_o(pm_o), .dec_o(dec_o), .pm_valid_o(pm_valid_o)
  );

  // columns: pattern mode, seed, expected decision of state 0 (-1 = from model)
  localparam int TBL_N = 8;
  localparam int TBL [TBL_N][3] = '{
    '{0, 0,  0}, '{1, 0,  0}, '{2, 0,  3}, '{3, 0,  0},
    '{4, 11, -1}, '{4, 23, -1}, '{5, 7, -1}, '{4, 91, -1}
  };

  function automatic int pat(int mode, int seed, int j, int k);
    case (mode)
      0: return 0;
      1: return 5;
      2: return k * 7;
      3: return (3 - k) * 7;
      4: return ((j * 37 + k * 101 + seed * 53) ^ (seed * 29 + j)) & 255;
      default: return (j * 3 + seed) & 255;
    endcase
  endfunction

  task automatic pack_bm();
    for (int j = 0; j < N; j++)
      for (int k = 0; k < 4; k++)
        bm_i[(j*4+k)*BMW +: BMW] = BMW'(bmv[j][k]);
  endtask

  task automatic model_step();
    longint nm[N];
    for (int j = 0; j < N; j++) begin
      longint best = -1;
      int bk = 0;
      for (int k = 0; k < 4; k++) begin
        longint c = ref_pm[(j >> 2) + k*NG] + longint'(bmv[j][k]);
        if (c > best) begin best = c; bk = k; end
      end
      nm[j] = best;
      ref_dec[j] = bk;
    end
    for (int j = 0; j < N; j++) ref_pm[j] = nm[j];
  endtask

  task automatic check_outputs(string rq, logic exp_valid);
    int bm_bad = -1, bd_bad = -1;
    checks++;
    if (pm_valid_o !== exp_valid) begin
      errors++;
      $display("FAIL %s valid: got %0b exp %0b", rq, pm_valid_o, exp_valid);
    end
    for (int j = 0; j < N; j++) begin
      logic [MW-1:0] e;
      e = ref_pm[j][MW-1:0];
      if (bm_bad < 0 && pm_o[j*MW +: MW] !== e) bm_bad = j;
      if (bd_bad < 0 && dec_o[j*2 +: 2] !== 2'(ref_dec[j])) bd_bad = j;
    end
    checks++;
    if (bm_bad >= 0) begin
      errors++;
      $display("FAIL %s metric state %0d: got %0d exp %0d", rq, bm_bad,
               pm_o[bm_bad*MW +: MW], ref_pm[bm_bad][MW-1:0]);
    end
    checks++;
    if (bd_bad >= 0) begin
      errors++;
      $display("FAIL %s decision state %0d: got %0d exp %0d", rq, bd_bad,
               dec_o[bd_bad*2 +: 2], ref_dec[bd_bad]);
    end
  endtask

  // entered at a negedge; returns at the negedge where the result is visible
  task automatic run_symbol(string rq, bit imm);
    if (!imm) @(negedge clk);
    pack_bm();
    sym_valid_i = 1'b1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    sym_valid_i = 1'b0;
    bm_i = ~bm_i;  // odd states must use the captured copy
    @(posedge clk);
    @(negedge clk);
    check_outputs(rq, 1'b1);
  endtask

  task automatic clear_model();
    for (int j = 0; j < N; j++) begin ref_pm[j] = 0; ref_dec[j] = 0; end
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    check_outputs("R1 reset", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_outputs("R1 after reset", 1'b0);

    // table walk: ties, slot ramps, mapping patterns
    for (int t = 0; t < TBL_N; t++) begin
      for (int j = 0; j < N; j++)
        for (int k = 0; k < 4; k++)
          bmv[j][k] = pat(TBL[t][0], TBL[t][1], j, k);
      run_symbol("R2 R3 R4 R6", 1'b0);
      if (TBL[t][2] >= 0) begin
        checks++;
        if (dec_o[1:0] !== 2'(TBL[t][2])) begin
          errors++;
          $display("FAIL R4 table row %0d dec0: got %0d exp %0d", t, dec_o[1:0], TBL[t][2]);
        end
      end
    end

    // R8: outputs hold with no strobe
    repeat (3) @(negedge clk);
    check_outputs("R8 hold", 1'b0);

    // R7: strobe held for two edges, second bus differs
    for (int j = 0; j < N; j++)
      for (int k = 0; k < 4; k++) bmv[j][k] = pat(4, 5, j, k);
    pack_bm();
    sym_valid_i = 1'b1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < N*4; p++) bm_i[p*BMW +: BMW] = 8'd200;
    @(posedge clk);
    @(negedge clk);
    sym_valid_i = 1'b0;
    check_outputs("R7 first update", 1'b1);
    @(negedge clk);
    check_outputs("R7 no second update", 1'b0);
    @(negedge clk);
    check_outputs("R7 still held", 1'b0);

    // R9 and R5: strobe every second clock, long enough to wrap
    for (int s = 0; s < 80; s++) begin
      for (int j = 0; j < N; j++)
        for (int k = 0; k < 4; k++) bmv[j][k] = $urandom_range(255, 0);
      run_symbol(s == 79 ? "R5 wrap" : "R9 back-to-back", s != 0);
    end
    checks++;
    if (ref_pm[0] < 3 * (1 << MW)) begin
      errors++;
      $display("FAIL R5 wrap not reached: got %0d exp >= %0d", ref_pm[0], 3 * (1 << MW));
    end

    // R1: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clear_model();
    rst = 1'b0;
    @(negedge clk);
    check_outputs("R1 mid-run reset", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule